// File: doc/BRIEF.md
# Cold Reset Sequencer with Boot Vector Capture

This block runs the power-up cold reset of a processor. While the active-low cold reset input is held, it lets go of the low sixteen address lines so that board logic can present a boot configuration word on them. It keeps driving the upper address lines and holds the shared open-drain reset pin low. When cold reset is released, the block keeps the word that stood on the lines two clock edges earlier and takes back the low address lines after a fixed short delay. It then waits for PLL lock and enables the external clock output.

Two long timed windows follow, and one down-counter times both. The first runs from clock start to the release of the reset pin. The second runs from that release to a read-back of the pin. A high read-back ends the sequence with a one-cycle start pulse to the core. A low read-back means some other agent still holds reset, and the block waits. Asserting cold reset again at any point aborts the sequence at once.

Top module: `coldrst_seq`

## Requirements
- R1: While cold_rst_ni is low, addr_lo_oe_o is 0 in the same cycle, and addr_hi_oe_o is 1 at all times.
- R2: rst_pin_oe_o is 1, which pulls the reset pin low, in the same cycle that cold_rst_ni is low.
- R3: Call E the first clock edge that samples cold_rst_ni high. At E, boot_vec_o takes the addr_lo_i value sampled two edges before E, and boot_vec_valid_o becomes 1. Any edge that samples cold_rst_ni low clears boot_vec_valid_o.
- R4: addr_lo_oe_o becomes 1 after exactly REDRIVE_DLY edges past E (default 8). Legal values of REDRIVE_DLY are 1 to 16.
- R5: After the low lines are driven again, ext_clk_en_o stays 0 until an edge samples pll_lock_i high. It is 1 after that edge.
- R6: Call P the edge that samples pll_lock_i high. rst_pin_oe_o stays 1 through edge P+WIN_CYCLES and is 0 after edge P+WIN_CYCLES+1 (default WIN_CYCLES is 4000).
- R7: Call H the edge that releases the pin. The pin is sampled at edge H+WIN_CYCLES+1. If it reads high, core_start_o is 1 for exactly one cycle after that edge. After that, rst_pin_oe_o stays 0 and ext_clk_en_o stays 1.
- R8: If the pin reads low at that sample, core_start_o stays 0. The block samples the pin at every following edge and pulses core_start_o after the first edge that sees it high.
- R9: Asserting cold_rst_ni low in any state forces addr_lo_oe_o to 0 and rst_pin_oe_o to 1 at once. After the next edge, ext_clk_en_o, boot_vec_valid_o and core_start_o are 0, and the next release starts a fresh capture.
- R10: Asserting rst_ni low asynchronously sets ext_clk_en_o, boot_vec_valid_o and core_start_o to 0 and sets rst_pin_oe_o to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cold_rst_ni | input | 1 | Cold reset request, active low |
| addr_lo_i | input | 16 | Low address pins, sampled as the boot word |
| pll_lock_i | input | 1 | PLL lock indication |
| rst_pin_i | input | 1 | Read-back of the open-drain reset pin |
| addr_lo_oe_o | output | 1 | Output enable for the low address lines |
| addr_hi_oe_o | output | 1 | Output enable for the upper address lines |
| rst_pin_oe_o | output | 1 | Pulls the reset pin low when 1 |
| ext_clk_en_o | output | 1 | Enables the external clock output |
| boot_vec_o | output | 16 | Captured boot configuration word |
| boot_vec_valid_o | output | 1 | Captured word is valid |
| core_start_o | output | 1 | One-cycle start pulse to the core |

## Verification
The output enables react to cold_rst_ni without waiting for a clock, so the bench checks them 1 ns after it drives the input. Every other result is due a fixed number of edges after its cause: the captured word one edge after release, the low-line enable REDRIVE_DLY edges after release, and the clock enable one edge after lock. The pin release comes WIN_CYCLES+1 edges after lock, and the start pulse WIN_CYCLES+1 edges after the pin release. Inputs change on falling edges, and each check samples on the falling edge just before and just after the rising edge that is due. This catches an output that moves one cycle early or one cycle late.

// File: rtl/coldrst_pkg.sv
package coldrst_pkg;
  // State order matters: enables are decoded by range compares.
  typedef enum logic [2:0] {
    IDLE_RESET    = 3'd0,
    RELEASE_DRIVE = 3'd1,
    WAIT_PLL      = 3'd2,
    CLK_START     = 3'd3,
    HOLD_RSTN     = 3'd4,
    RELEASE_RSTN  = 3'd5,
    CHECK_RSTN    = 3'd6,
    RUN           = 3'd7
  } seq_state_e;
endpackage

// File: rtl/coldrst_win_cnt.sv
module coldrst_win_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // Counter saturates at zero; the windows never wrap (R6)
  p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o && !load_i |=> zero_o);
endmodule

// File: rtl/coldrst_vec_cap.sv
module coldrst_vec_cap #(
  parameter int VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cold_ni,
  input  logic [VEC_W-1:0] pins_i,
  input  logic             capture_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             valid_o
);
  logic [VEC_W-1:0] hist_q [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q[0] <= '0;
      hist_q[1] <= '0;
    end else begin
      hist_q[0] <= pins_i;
      hist_q[1] <= hist_q[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o   <= '0;
      valid_o <= 1'b0;
    end else if (capture_i) begin
      vec_o   <= hist_q[1];
      valid_o <= 1'b1;
    end else if (!cold_ni) begin
      valid_o <= 1'b0;
    end
  end

  p_valid_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_ni |=> !valid_o);
  p_vec_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(vec_o));
endmodule

// File: rtl/coldrst_seq.sv
module coldrst_seq
  import coldrst_pkg::*;
#(
  parameter int VEC_W       = 16,
  parameter int REDRIVE_DLY = 8,
  parameter int WIN_CYCLES  = 4000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cold_rst_ni,
  input  logic [VEC_W-1:0] addr_lo_i,
  input  logic             pll_lock_i,
  input  logic             rst_pin_i,
  output logic             addr_lo_oe_o,
  output logic             addr_hi_oe_o,
  output logic             rst_pin_oe_o,
  output logic             ext_clk_en_o,
  output logic [VEC_W-1:0] boot_vec_o,
  output logic             boot_vec_valid_o,
  output logic             core_start_o
);
  localparam int CNT_MAX = (WIN_CYCLES > REDRIVE_DLY) ? WIN_CYCLES : REDRIVE_DLY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WIN_LD = CNT_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] DRV_LD = CNT_W'(REDRIVE_DLY - 1);

  initial begin
    a_redrive_range_r4: assert (REDRIVE_DLY >= 1 && REDRIVE_DLY <= 16)
      else $error("REDRIVE_DLY out of range 1..16");
  end

  seq_state_e       state_q, state_d;
  logic             cnt_load, cnt_zero, capture, start_d, start_q;
  logic [CNT_W-1:0] cnt_val;

  coldrst_win_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  coldrst_vec_cap #(.VEC_W(VEC_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cold_ni   (cold_rst_ni),
    .pins_i    (addr_lo_i),
    .capture_i (capture),
    .vec_o     (boot_vec_o),
    .valid_o   (boot_vec_valid_o)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = WIN_LD;
    capture  = 1'b0;
    start_d  = 1'b0;
    if (!cold_rst_ni) begin
      state_d = IDLE_RESET;
    end else begin
      unique case (state_q)
        IDLE_RESET: begin
          capture  = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = DRV_LD;
          state_d  = RELEASE_DRIVE;
        end
        RELEASE_DRIVE: if (cnt_zero) state_d = WAIT_PLL;
        WAIT_PLL:      if (pll_lock_i) state_d = CLK_START;
        CLK_START: begin
          cnt_load = 1'b1;
          state_d  = HOLD_RSTN;
        end
        HOLD_RSTN: if (cnt_zero) begin
          cnt_load = 1'b1;
          state_d  = RELEASE_RSTN;
        end
        RELEASE_RSTN: if (cnt_zero) state_d = CHECK_RSTN;
        CHECK_RSTN: if (rst_pin_i) begin
          start_d = 1'b1;
          state_d = RUN;
        end
        RUN:     state_d = RUN;
        default: state_d = IDLE_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= IDLE_RESET;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  // Pin enables follow cold reset without waiting for a clock edge
  assign addr_lo_oe_o = cold_rst_ni && (state_q > RELEASE_DRIVE);
  assign addr_hi_oe_o = 1'b1;
  assign rst_pin_oe_o = !cold_rst_ni || (state_q <= HOLD_RSTN);
  assign ext_clk_en_o = cold_rst_ni && (state_q >= CLK_START);
  assign core_start_o = start_q;

  p_redrive_after_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_lo_oe_o) |-> $past(boot_vec_valid_o));
  p_clk_needs_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_clk_en_o) |-> $past(pll_lock_i));
  p_rst_release_clocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_pin_oe_o) |-> ext_clk_en_o);
  p_start_pin_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_start_o) |-> $past(rst_pin_i) && !rst_pin_oe_o);
  p_start_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);
  p_cold_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_rst_ni |=> !boot_vec_valid_o && !core_start_o);
endmodule

// File: tb/coldrst_seq_bench.sv
`timescale 1ns/1ps
module coldrst_seq_bench;
  localparam int W = 4000;
  localparam int D = 8;

  typedef struct packed {
    logic [15:0] vec;
    logic [15:0] tail;
    logic [7:0]  pll_wait;
    logic [7:0]  pull_extra;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{16'hA5C3, 16'h5A3C, 8'd0,  8'd0},
    '{16'h0001, 16'hFFFE, 8'd3,  8'd0},
    '{16'hBEEF, 16'h4110, 8'd10, 8'd5},
    '{16'h8000, 16'h7FFF, 8'd1,  8'd1}
  };

  logic clk = 1'b0, rst_ni = 1'b0, cold_rst_ni = 1'b0, pll_lock = 1'b0, ext_pull = 1'b0;
  logic [15:0] addr_lo = '0;
  logic rst_pin, lo_oe, hi_oe, rst_oe, ext_en, valid, start;
  logic [15:0] bvec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // Open-drain pin: low if the block or an external agent pulls it
  assign rst_pin = ~rst_oe & ~ext_pull;

  coldrst_seq u_coldrst_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cold_rst_ni(cold_rst_ni), .addr_lo_i(addr_lo),
    .pll_lock_i(pll_lock), .rst_pin_i(rst_pin), .addr_lo_oe_o(lo_oe),
    .addr_hi_oe_o(hi_oe), .rst_pin_oe_o(rst_oe), .ext_clk_en_o(ext_en),
    .boot_vec_o(bvec), .boot_vec_valid_o(valid), .core_start_o(start)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Present vec, then tail, then release; ends just after edge E
  task automatic release_with(logic [15:0] v, logic [15:0] t);
    addr_lo = v; tick(3);
    addr_lo = t; tick(1);
    cold_rst_ni = 1'b1; addr_lo = ~v; tick(1);
    chk("R3 valid", valid, 1);
    chk("R3 vec", bvec, v);
  endtask

  task automatic run_vec(vec_t v);
    release_with(v.vec, v.tail);
    tick(D - 1);
    chk("R4 lo_oe early", lo_oe, 0);
    tick(1);
    chk("R4 lo_oe on", lo_oe, 1);
    chk("R1 hi_oe", hi_oe, 1);
    tick(v.pll_wait);
    chk("R5 ext before lock", ext_en, 0);
    pll_lock = 1'b1; tick(1);
    chk("R5 ext after lock", ext_en, 1);
    tick(W);
    chk("R6 rst held", rst_oe, 1);
    tick(1);
    chk("R6 rst released", rst_oe, 0);
    if (v.pull_extra != 0) ext_pull = 1'b1;
    tick(W);
    chk("R7 no early start", start, 0);
    tick(1);
    if (v.pull_extra == 0) begin
      chk("R7 start", start, 1);
    end else begin
      chk("R8 held pin no start", start, 0);
      tick(v.pull_extra);
      chk("R8 still waiting", start, 0);
      ext_pull = 1'b0; tick(1);
      chk("R8 start after pin high", start, 1);
    end
    tick(1);
    chk("R7 pulse ends", start, 0);
    chk("R7 rst stays off", rst_oe, 0);
    chk("R7 ext stays on", ext_en, 1);
    cold_rst_ni = 1'b0; pll_lock = 1'b0; #1;
    chk("R2 rst_oe immediate", rst_oe, 1);
    chk("R1 lo_oe immediate", lo_oe, 0);
    tick(1);
    chk("R9 ext cleared", ext_en, 0);
    chk("R9 valid cleared", valid, 0);
  endtask

  initial begin
    tick(2);
    chk("R10 ext", ext_en, 0);
    chk("R10 valid", valid, 0);
    chk("R10 start", start, 0);
    chk("R10 rst_oe", rst_oe, 1);
    chk("R1 lo_oe in reset", lo_oe, 0);
    chk("R1 hi_oe in reset", hi_oe, 1);
    rst_ni = 1'b1; tick(2);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: abort during redrive delay, then fresh capture
    release_with(16'h1234, 16'h4321);
    tick(3);
    cold_rst_ni = 1'b0; #1;
    chk("R9 rst_oe on abort", rst_oe, 1);
    tick(1);
    chk("R9 valid cleared on abort", valid, 0);
    release_with(16'hC0DE, 16'h0F0F);
    tick(D);
    chk("R9 R4 redrive after restart", lo_oe, 1);

    // R9: abort during the hold window
    pll_lock = 1'b1; tick(20);
    chk("R9 in hold ext", ext_en, 1);
    cold_rst_ni = 1'b0; pll_lock = 1'b0; #1;
    chk("R9 lo_oe off in hold", lo_oe, 0);
    chk("R9 rst_oe on in hold", rst_oe, 1);
    tick(1);
    chk("R9 ext off after hold abort", ext_en, 0);

    // R10: async reset while running
    release_with(16'h5555, 16'hAAAA);
    tick(D); pll_lock = 1'b1; tick(5);
    rst_ni = 1'b0; #1;
    chk("R10 async ext", ext_en, 0);
    chk("R10 async valid", valid, 0);
    chk("R10 async rst_oe", rst_oe, 1);
    tick(1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule